// File: doc/BRIEF.md
# Throttled Single-Channel DMA Engine

This block is one DMA channel. It copies a run of bytes from a source region to a destination region. Software loads a source address, a destination address, a byte count and a control word through a small register port, then sets the start bit. The engine then alternates read beats and write beats on a bus master port until the remaining count is zero. When the run ends it raises a done flag.

Each beat is 1, 2, 4 or 16 bytes wide. The source and destination can each have their own beat size and their own increment setting. Read data is collected in a 16-byte staging buffer. A unit of work is one pass that fills the buffer to the larger of the two beat sizes and then drains it.

To share the bus, the channel can give up its request for one idle cycle each time the remaining count lands on a power-of-two block boundary. The block size comes from a 3-bit throttle code. A count-width mode bit selects which of two tables of block sizes that code indexes.

The beat port is valid/ready. Once `m_valid` is raised, the beat's address, size, direction and write data stay frozen until `m_ready` is seen high at a clock edge. The slave may hold `m_ready` low for any number of cycles. Read data must be valid on `m_rdata` in the cycle in which `m_ready` is high for a read beat. `bus_req` is high exactly when the channel is presenting beats.

Top module: `dma_bw_chan`

## Requirements
- R1: The register port has four locations, selected by `cfg_wsel` and `cfg_rsel`: 0 = source address, 1 = destination address, 2 = byte count, 3 = control word. Control word fields:
  - bit 0: start (write-only pulse; always reads back as 0)
  - bits 2:1: source size
  - bits 4:3: destination size
  - bit 5: source increment
  - bit 6: destination increment
  - bits 9:7: throttle code
  - bit 10: wide-count mode
  - bit 11: done-clear (write-only)
- R2: Size codes are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes, 11 = 16 bytes. Every read beat carries the source size code on `m_size` and every write beat carries the destination size code. Data is right-justified and little-endian on `m_rdata` and `m_wdata`.
- R3: With source increment set, the source address advances by the source beat size after every accepted read beat. With it clear, the source address never changes.
- R4: With destination increment set, the destination address advances by the destination beat size after every accepted write beat. With it clear, the destination address never changes.
- R5: Each unit is made of read beats that fill the buffer to max(source size, destination size) bytes, followed by write beats that drain it in the same byte order. The byte stream written equals the byte stream read.
- R6: The count drops by the destination size after each accepted write beat. At zero the channel goes idle and sets `done`. A start with a zero count sets `done` without issuing any beat.
- R7: Throttle code 000 never releases the bus during a run.
- R8: With wide-count mode at 0, throttle codes 1 to 7 select block sizes of 512 bytes doubling up to 32768 bytes.
- R9: With wide-count mode at 1, throttle codes 1 to 7 select block sizes of 16384 bytes doubling up to 1048576 bytes.
- R10: After a unit that leaves a nonzero remaining count which is a multiple of the block size, `bus_req` drops for exactly one cycle and the run then continues. No release happens when the count reaches zero. A run of N bytes therefore releases floor((N-1)/block) times.
- R11: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_write` and `m_size` hold their values.
- R12: While `busy` is high, writes to every register are ignored, including a second start. A done-clear write clears `done`, and a start also clears `done`.
- R13: With wide-count mode at 0, a start keeps only the low 16 bits of the count. With wide-count mode at 1, all 24 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wsel | input | 2 | Register write select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rsel | input | 2 | Register read select |
| cfg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished flag |
| bus_req | output | 1 | Bus request, dropped during throttle gaps |
| m_valid | output | 1 | Beat valid |
| m_ready | input | 1 | Beat accepted |
| m_write | output | 1 | 1 = write beat, 0 = read beat |
| m_addr | output | 32 | Beat address |
| m_size | output | 2 | Beat size code |
| m_wdata | output | 128 | Write data, right-justified |
| m_rdata | input | 128 | Read data, right-justified |

## Verification
The assertions assume that the slave never fakes a handshake and returns read data in the accepting cycle. They also assume that every programmed count is a whole multiple of the unit size, so the count can never step past zero. The stimulus respects both assumptions. The bench memory model answers only beats that are actually presented and stalls them with random `m_ready`. Every random count is drawn as a unit size times a random multiplier, and the directed counts are chosen aligned in the same way.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int LINE_B = 16;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xsize_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RD,
    ST_WR,
    ST_GAP
  } eng_st_e;

  // Control word bits [10:1], most significant field first.
  typedef struct packed {
    logic       wide;
    logic [2:0] bw;
    logic       dinc;
    logic       sinc;
    logic [1:0] dsize;
    logic [1:0] ssize;
  } chan_cfg_t;

  function automatic logic [4:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_LONG: size_bytes = 5'd4;
      SZ_BYTE: size_bytes = 5'd1;
      SZ_WORD: size_bytes = 5'd2;
      default: size_bytes = 5'd16;
    endcase
  endfunction

  // log2 of block size: narrow mode code1 -> 2^9, wide mode code1 -> 2^14
  function automatic logic [4:0] blk_shift(input logic [2:0] bw, input logic wide);
    blk_shift = wide ? (5'd13 + {2'b00, bw}) : (5'd8 + {2'b00, bw});
  endfunction
endpackage

// File: rtl/dma_bwgate.sv
module dma_bwgate
  import dma_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic [2:0]       bw,
  input  logic             wide,
  output logic             hit
);
  logic [4:0] shift;
  logic       low_zero;

  always_comb begin
    shift    = blk_shift(bw, wide);
    low_zero = 1'b1;
    for (int i = 0; i < CNT_W; i++) begin
      if ((i < int'(shift)) && cnt_nx[i]) low_zero = 1'b0;
    end
    hit = (bw != 3'd0) && (cnt_nx != '0) && low_zero;
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CNT_W    = 24,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_sel,
  output logic [31:0]      rd_data,
  input  logic             busy,
  input  logic             eng_upd,
  input  logic [AW-1:0]    eng_src,
  input  logic [AW-1:0]    eng_dst,
  input  logic [CNT_W-1:0] eng_cnt,
  input  logic             eng_done,
  output logic [AW-1:0]    src_q,
  output logic [AW-1:0]    dst_q,
  output logic [CNT_W-1:0] cnt_q,
  output chan_cfg_t        cfg_q,
  output logic             go_pulse,
  output logic             done_q
);
  localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((64'd1 << NARROW_W) - 64'd1);

  logic ctrl_wr;
  logic clr_wr;
  logic [CNT_W-1:0] keep_mask;
  wire  unused_hi = ^wr_data[31:12];

  assign ctrl_wr   = wr_en && (wr_sel == 2'd3);
  assign go_pulse  = ctrl_wr && wr_data[0] && !busy;
  assign clr_wr    = ctrl_wr && wr_data[11];
  assign keep_mask = wr_data[10] ? '1 : NARROW_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      cfg_q <= '0;
    end else if (eng_upd) begin
      src_q <= eng_src;
      dst_q <= eng_dst;
      cnt_q <= eng_cnt;
    end else if (wr_en && !busy) begin
      case (wr_sel)
        2'd0: src_q <= wr_data[AW-1:0];
        2'd1: dst_q <= wr_data[AW-1:0];
        2'd2: cnt_q <= wr_data[CNT_W-1:0];
        default: begin
          cfg_q <= chan_cfg_t'(wr_data[10:1]);
          if (wr_data[0]) cnt_q <= cnt_q & keep_mask;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          done_q <= 1'b0;
    else if (go_pulse)   done_q <= 1'b0;
    else if (eng_done)   done_q <= 1'b1;
    else if (clr_wr)     done_q <= 1'b0;
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = 32'(src_q);
      2'd1:    rd_data = 32'(dst_q);
      2'd2:    rd_data = 32'(cnt_q);
      default: rd_data = {21'd0, cfg_q, 1'b0};
    endcase
  end

  // R12: with the engine running and not stepping, the registers are frozen
  p_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_upd) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(cfg_q)));

  // R12: a done-clear write with no simultaneous completion clears the flag
  p_done_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !eng_done) |=> !done_q);

  // R13: narrow start keeps only the low count bits
  p_narrow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse && !wr_data[10]) |=> ((cnt_q & ~NARROW_MASK) == '0));
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 24,
  parameter int BUF_B = LINE_B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [AW-1:0]      src,
  input  logic [AW-1:0]      dst,
  input  logic [CNT_W-1:0]   cnt,
  input  chan_cfg_t          cfg,
  output logic               busy,
  output logic               bus_req,
  output logic               m_valid,
  input  logic               m_ready,
  output logic               m_write,
  output logic [AW-1:0]      m_addr,
  output logic [1:0]         m_size,
  output logic [BUF_B*8-1:0] m_wdata,
  input  logic [BUF_B*8-1:0] m_rdata,
  output logic               eng_upd,
  output logic [AW-1:0]      eng_src,
  output logic [AW-1:0]      eng_dst,
  output logic [CNT_W-1:0]   eng_cnt,
  output logic               eng_done
);
  localparam int BUF_W = BUF_B * 8;
  localparam int OFF_W = $clog2(BUF_B) + 1;

  eng_st_e st;
  logic [7:0] buf_q [BUF_B];
  logic [BUF_W-1:0] buf_flat;
  logic [OFF_W-1:0] rd_off, wr_off;
  logic [4:0] sb, db, unit;
  logic rd_fire, wr_fire, rd_end, wr_end, rel_hit;
  logic [BUF_B-1:0] lane_mask;
  logic [BUF_W-1:0] shifted;

  always_comb begin
    sb      = size_bytes(cfg.ssize);
    db      = size_bytes(cfg.dsize);
    unit    = (sb > db) ? sb : db;
    m_valid = (st == ST_RD) || (st == ST_WR);
    m_write = (st == ST_WR);
    bus_req = m_valid;
    busy    = (st != ST_IDLE);
    m_addr  = m_write ? dst : src;
    m_size  = m_write ? cfg.dsize : cfg.ssize;
    m_wdata = buf_flat >> {wr_off, 3'b000};
    rd_fire = (st == ST_RD) && m_ready;
    wr_fire = (st == ST_WR) && m_ready;
    rd_end  = (6'(rd_off) + 6'(sb)) >= 6'(unit);
    wr_end  = (6'(wr_off) + 6'(db)) >= 6'(unit);
    eng_upd = rd_fire || wr_fire;
    eng_src = (rd_fire && cfg.sinc) ? src + AW'(sb) : src;
    eng_dst = (wr_fire && cfg.dinc) ? dst + AW'(db) : dst;
    eng_cnt = wr_fire ? cnt - CNT_W'(db) : cnt;
    lane_mask = BUF_B'(((33'd1 << sb) - 33'd1) << rd_off);
    shifted   = m_rdata << {rd_off, 3'b000};
  end

  dma_bwgate #(.CNT_W(CNT_W)) u_gate (
    .cnt_nx (eng_cnt),
    .bw     (cfg.bw),
    .wide   (cfg.wide),
    .hit    (rel_hit)
  );

  for (genvar j = 0; j < BUF_B; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                         buf_q[j] <= 8'd0;
      else if (rd_fire && lane_mask[j])   buf_q[j] <= shifted[j*8 +: 8];
    end
    assign buf_flat[j*8 +: 8] = buf_q[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rd_off   <= '0;
      wr_off   <= '0;
      eng_done <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      case (st)
        ST_IDLE: if (go) st <= ST_ARM;
        ST_ARM: begin
          rd_off <= '0;
          if (cnt == '0) begin
            st       <= ST_IDLE;
            eng_done <= 1'b1;
          end else begin
            st <= ST_RD;
          end
        end
        ST_RD: if (m_ready) begin
          if (rd_end) begin
            st     <= ST_WR;
            wr_off <= '0;
          end else begin
            rd_off <= rd_off + OFF_W'(sb);
          end
        end
        ST_WR: if (m_ready) begin
          if (wr_end) begin
            rd_off <= '0;
            if (eng_cnt == '0) begin
              st       <= ST_IDLE;
              eng_done <= 1'b1;
            end else if (rel_hit) begin
              st <= ST_GAP;
            end else begin
              st <= ST_RD;
            end
          end else begin
            wr_off <= wr_off + OFF_W'(db);
          end
        end
        default: st <= ST_RD;
      endcase
    end
  end

  // R11: a stalled beat keeps its attributes
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_size)));

  // R10: a release inside a run lasts one cycle
  p_gap_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && busy) |=> bus_req);

  // R10: no release on an exhausted count
  p_gap_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> (cnt != '0));

  // R6: the bus is never requested with nothing left to move
  p_req_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (cnt != '0));

  // R6: the stored count steps down by the write size
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (cnt == $past(cnt) - CNT_W'($past(db))));
endmodule

// File: rtl/dma_bw_chan.sv
module dma_bw_chan
  import dma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CNT_W    = 24,
  parameter int NARROW_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_wsel,
  input  logic [31:0]  cfg_wdata,
  input  logic [1:0]   cfg_rsel,
  output logic [31:0]  cfg_rdata,
  output logic         busy,
  output logic         done,
  output logic         bus_req,
  output logic         m_valid,
  input  logic         m_ready,
  output logic         m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]   m_size,
  output logic [127:0] m_wdata,
  input  logic [127:0] m_rdata
);
  logic [AW-1:0]    src_q, dst_q, eng_src, eng_dst;
  logic [CNT_W-1:0] cnt_q, eng_cnt;
  chan_cfg_t        cfg_q;
  logic             go_pulse, eng_upd, eng_done;

  dma_regs #(.AW(AW), .CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_wsel),
    .wr_data  (cfg_wdata),
    .rd_sel   (cfg_rsel),
    .rd_data  (cfg_rdata),
    .busy     (busy),
    .eng_upd  (eng_upd),
    .eng_src  (eng_src),
    .eng_dst  (eng_dst),
    .eng_cnt  (eng_cnt),
    .eng_done (eng_done),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .cnt_q    (cnt_q),
    .cfg_q    (cfg_q),
    .go_pulse (go_pulse),
    .done_q   (done)
  );

  dma_xfer #(.AW(AW), .CNT_W(CNT_W), .BUF_B(LINE_B)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go_pulse),
    .src      (src_q),
    .dst      (dst_q),
    .cnt      (cnt_q),
    .cfg      (cfg_q),
    .busy     (busy),
    .bus_req  (bus_req),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_write  (m_write),
    .m_addr   (m_addr),
    .m_size   (m_size),
    .m_wdata  (m_wdata),
    .m_rdata  (m_rdata),
    .eng_upd  (eng_upd),
    .eng_src  (eng_src),
    .eng_dst  (eng_dst),
    .eng_cnt  (eng_cnt),
    .eng_done (eng_done)
  );

  // R1: start bit never reads back as set
  p_go_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rsel == 2'd3) |-> (cfg_rdata[0] == 1'b0));

  // R6: done and an active run never overlap
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !done);
endmodule

// File: tb/tb_dma_bw_chan.sv
module tb_dma_bw_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wsel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0] cfg_rsel = '0;
  logic [31:0] cfg_rdata;
  logic busy, done, bus_req, m_valid, m_write;
  logic m_ready = 1'b0;
  logic [31:0] m_addr;
  logic [1:0] m_size;
  logic [127:0] m_wdata;
  logic [127:0] m_rdata = '0;

  always #2 clk = ~clk;

  dma_bw_chan dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .busy(busy), .done(done), .bus_req(bus_req), .m_valid(m_valid),
    .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  int checks = 0;
  int fails = 0;
  int unsigned j_src, j_dst, j_cnt;
  int j_ss, j_ds, j_si, j_di, j_bw, j_wide;
  int rd_idx, wr_idx, rel_cycles;
  bit seen_req = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(input int code);
    case (code)
      0: return 4;
      1: return 1;
      2: return 2;
      default: return 16;
    endcase
  endfunction

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic int blk_log2(input int bw, input int wide);
    return wide ? 13 + bw : 8 + bw;
  endfunction

  function automatic int exp_releases(input int unsigned n, input int bw, input int wide);
    if (bw == 0 || n == 0) return 0;
    return int'((n - 1) >> blk_log2(bw, wide));
  endfunction

  function automatic logic [31:0] mk_ctrl(input int ss, input int ds, input int si,
                                          input int di, input int bw, input int wide);
    logic [31:0] c;
    c = '0;
    c[2:1] = ss[1:0]; c[4:3] = ds[1:0]; c[5] = si[0]; c[6] = di[0];
    c[9:7] = bw[2:0]; c[10] = wide[0];
    return c;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    cfg_rsel = sel;
    #1;
    v = cfg_rdata;
  endtask

  // Slave model and throttle monitor
  initial begin
    forever begin
      @(negedge clk);
      if (busy && !bus_req && seen_req) begin
        longint unsigned blk;
        rel_cycles++;
        blk = 64'd1 << blk_log2(j_bw, j_wide);
        chk((cfg_rdata != 0) && ((cfg_rdata % blk) == 0), "R10", "release off boundary",
            cfg_rdata, blk);
      end
      if (bus_req) seen_req = 1;
      if (m_valid && ($urandom_range(3) != 0)) begin
        m_ready = 1'b1;
        if (!m_write) begin
          int sb;
          logic [31:0] ea;
          sb = nbytes(j_ss);
          ea = j_src + (j_si ? rd_idx : 0);
          chk(m_addr == ea, "R3", "read address", m_addr, ea);
          chk(m_size == j_ss[1:0], "R2", "read size", m_size, j_ss);
          m_rdata = '0;
          for (int i = 0; i < sb; i++) m_rdata[i*8 +: 8] = mem_byte(m_addr + i);
          rd_idx += sb;
        end else begin
          int db, sb, k;
          bit ok;
          logic [31:0] ea, sa;
          logic [7:0] eb;
          db = nbytes(j_ds); sb = nbytes(j_ss);
          ea = j_dst + (j_di ? wr_idx : 0);
          chk(m_addr == ea, "R4", "write address", m_addr, ea);
          chk(m_size == j_ds[1:0], "R2", "write size", m_size, j_ds);
          ok = 1;
          eb = '0;
          for (int i = 0; i < db; i++) begin
            k = wr_idx + i;
            sa = j_src + (j_si ? k : (k % sb));
            if (m_wdata[i*8 +: 8] != mem_byte(sa)) begin ok = 0; eb = mem_byte(sa); end
          end
          chk(ok, "R5", "write data byte", m_wdata[31:0], eb);
          wr_idx += db;
        end
      end else begin
        m_ready = 1'b0;
      end
    end
  end

  task automatic run_job(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n,
                         input int ss, input int ds, input int si, input int di,
                         input int bw, input int wide, input bit poke);
    logic [31:0] c, v;
    int w;
    string rq;
    j_src = s; j_dst = d; j_ss = ss; j_ds = ds; j_si = si; j_di = di;
    j_bw = bw; j_wide = wide;
    j_cnt = wide ? (n & 32'hFF_FFFF) : (n & 32'hFFFF);
    rd_idx = 0; wr_idx = 0; rel_cycles = 0; seen_req = 0;
    c = mk_ctrl(ss, ds, si, di, bw, wide);
    wr(2'd0, s); wr(2'd1, d); wr(2'd2, n);
    cfg_rsel = 2'd2;
    wr(2'd3, c | 32'd1);
    if (poke && busy) begin
      wr(2'd0, 32'hDEAD_0000);                          // R12 ignored while busy
      wr(2'd3, mk_ctrl(3 - ss, 3 - ds, 1 - si, 1 - di, 0, 0) | 32'd1);
      cfg_rsel = 2'd2;
    end
    w = 0;
    while (!done && w < 100000) begin @(negedge clk); w++; end
    rq = (bw == 0) ? "R7" : (wide ? "R9" : "R8");
    chk(done, "R6", "done after run", done, 1);
    chk(rd_idx == j_cnt, "R5", "bytes read", rd_idx, j_cnt);
    chk(wr_idx == j_cnt, "R6", "bytes written", wr_idx, j_cnt);
    chk(rel_cycles == exp_releases(j_cnt, bw, wide), rq, "release cycles",
        rel_cycles, exp_releases(j_cnt, bw, wide));
    rd(2'd0, v);
    chk(v == j_src + (si ? j_cnt : 0), "R3", "final source", v, j_src + (si ? j_cnt : 0));
    rd(2'd1, v);
    chk(v == j_dst + (di ? j_cnt : 0), "R4", "final destination", v, j_dst + (di ? j_cnt : 0));
    rd(2'd2, v);
    chk(v == 0, "R6", "final count", v, 0);
    rd(2'd3, v);
    chk(v == c, "R12", "control unchanged", v, c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !bus_req && !m_valid, "R1", "reset outputs",
        {busy, done, bus_req, m_valid}, 0);
    rd(2'd2, v); chk(v == 0, "R1", "reset count", v, 0);

    // R1 register map and start bit readback
    wr(2'd0, 32'h1234_5678); rd(2'd0, v); chk(v == 32'h1234_5678, "R1", "source readback", v, 32'h1234_5678);
    wr(2'd1, 32'h0BAD_F00D); rd(2'd1, v); chk(v == 32'h0BAD_F00D, "R1", "dest readback", v, 32'h0BAD_F00D);
    wr(2'd3, 32'h0000_0FFE); rd(2'd3, v); chk(v == 32'h0000_07FE, "R1", "control readback", v, 32'h7FE);

    // Directed runs
    run_job(32'h0000_1000, 32'h0008_0000, 32'h1000, 0, 0, 1, 1, 1, 0, 0); // R8 7 releases
    rd(2'd3, v); chk(v[0] == 1'b0, "R1", "start reads zero", v[0], 0);
    run_job(32'h0000_2000, 32'h0009_0000, 32'h1100, 0, 0, 1, 1, 1, 0, 0); // R10 off boundary
    run_job(32'h0010_0000, 32'h0040_0000, 32'h8000, 3, 3, 1, 1, 1, 1, 0); // R9 one release
    run_job(32'h0000_3000, 32'h0000_7000, 32'h0400, 0, 0, 1, 1, 0, 0, 1); // R7 + R12 poke
    run_job(32'h0000_0101, 32'h0000_5000, 32'h0040, 1, 3, 1, 1, 0, 0, 0); // R5 mixed sizes
    run_job(32'h0000_0200, 32'h0000_6000, 32'h0020, 2, 0, 1, 0, 2, 0, 0); // R4 fixed dest
    run_job(32'h0000_0300, 32'h0000_6100, 32'h0010, 3, 1, 0, 1, 0, 0, 0); // R3 fixed source
    run_job(32'h0000_0400, 32'h0000_6800, 32'h000A_0200, 0, 0, 1, 1, 1, 0, 0); // R13 mask
    run_job(32'h0000_0500, 32'h0000_7800, 32'h0000_0800, 0, 2, 1, 1, 2, 1, 0); // R9 below block

    // R12 done clear
    chk(done, "R12", "done before clear", done, 1);
    wr(2'd3, 32'h0000_0800);
    chk(!done, "R12", "done after clear", done, 0);
    // R6 zero count start
    run_job(32'h0000_0600, 32'h0000_7000, 32'h0, 0, 0, 1, 1, 1, 0, 0);

    // Random runs
    for (int t = 0; t < 14; t++) begin
      int ss, ds, u, n;
      ss = $urandom_range(3); ds = $urandom_range(3);
      u = (nbytes(ss) > nbytes(ds)) ? nbytes(ss) : nbytes(ds);
      n = u * $urandom_range(1, 160);
      run_job($urandom & 32'h00FF_FFF0, $urandom & 32'h00FF_FFF0, n, ss, ds,
              $urandom_range(1), $urandom_range(1), $urandom_range(2), 0, t[0]);
    end

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule